// File: doc/BRIEF.md
# Single-Register Two-Wire Configuration Target

This block is an I2C target that owns one 8-bit configuration register and presents it to the rest of the chip as two independent 4-bit control codes: a bias-current code in the upper nibble and an impedance code in the lower nibble. The register is never addressed by index. Each transaction consists of an address byte and then exactly one data byte. On a write the master supplies that byte. On a read the target returns the current register value.

The 7-bit target address is strapped on static input pins. SCL and SDA are sampled by the faster system clock. Each line passes through a synchronizer and a stable-count filter before start, stop and clock edges are detected. The target drives SDA only through an open-drain enable, where a 1 pulls the line low, and it never stretches the clock. A reset or a one-cycle reload strobe restores the register to its fixed default of 0x7A.

There is no data stream at the block's edge, so every pin is a plain control or status signal. The block has no valid/ready handshake and applies no back-pressure. The configuration outputs are level signals and can be used in any cycle.

Top module: `cfg_i2c_target`

## Requirements
- R1: After reset the bias code is 4'b0111, the impedance code is 4'b1010 (register 0x7A), and the SDA pull-down enable is inactive.
- R2: The target acknowledges the first byte after a start, by pulling SDA low through the high phase of the ninth clock, only when bits 7..1 of that byte equal the address pins. Bit 0 selects the direction: 1 is read, 0 is write.
- R3: On an addressed write, the target acknowledges the data byte on the ninth clock and then loads it into the register. Bits 7..4 appear on the bias code and bits 3..0 on the impedance code.
- R4: On an addressed read, the target drives the register MSB first on the eight clocks that follow its address acknowledge. It leaves SDA released on the ninth clock.
- R5: A transaction carries one data byte only. A second byte after a write is not acknowledged and leaves the register unchanged.
- R6: A stop returns the target to idle with SDA released. A write byte that is only partly received when the stop arrives is discarded.
- R7: A start seen in the middle of a transaction aborts it and restarts address reception. The aborted partial data is not written.
- R8: A reload strobe restores the register to 0x7A on the next clock edge, taking priority over a write in the same cycle.
- R9: A pulse on SCL or SDA that is shorter than the filter length, counted in system clocks, creates no edge, start or stop.
- R10: When the address does not match, SDA stays released for the rest of the transaction: a read returns all ones and a write changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_pull_o | output | 1 | Open-drain enable; 1 pulls SDA low |
| dev_addr_i | input | 7 | Strapped 7-bit target address |
| reload_i | input | 1 | One-cycle strobe restoring the default register value |
| bias_code_o | output | 4 | Bias-current control code (register bits 7..4) |
| imp_code_o | output | 4 | Impedance control code (register bits 3..0) |

## Verification
A wrong bit counter or state shows on SDA within one SCL period. It appears as a missing or misplaced acknowledge, or as a read byte that is shifted or corrupt. A wrong register update shows on the two code outputs directly after the acknowledge clock of the write. A filter or condition detector that is too permissive turns an injected glitch into an extra clock or a false start, and this shows up as a wrong register value or a missing acknowledge in the same transaction.

// File: rtl/cfgi2c_pkg.sv
package cfgi2c_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR_BYTE,
    ST_WR_ACK,
    ST_RD_BYTE,
    ST_RD_ACK,
    ST_PARK
  } tgt_state_t;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned ADDR_W = 7;
  localparam int unsigned CODE_W = 4;
endpackage

// File: rtl/cfgi2c_line_filter.sv
module cfgi2c_line_filter #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_LEN    = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic clean_o
);
  localparam int unsigned CNT_W = $clog2(FILT_LEN + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CNT_W-1:0]       run_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q <= '1;
        else        sync_q <= raw_i;
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clean_o <= 1'b1;
      run_q   <= '0;
    end else if (sync_q[SYNC_STAGES-1] != clean_o) begin
      if (run_q == CNT_W'(FILT_LEN - 1)) begin
        clean_o <= sync_q[SYNC_STAGES-1];
        run_q   <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end else begin
      run_q <= '0;
    end
  end
endmodule

// File: rtl/cfgi2c_bus_events.sv
module cfgi2c_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic start_o,
  output logic stop_o,
  output logic scl_rise_o,
  output logic scl_fall_o
);
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_f;
      sda_d <= sda_f;
    end
  end

  always_comb begin
    start_o    = scl_f & scl_d & sda_d & ~sda_f;
    stop_o     = scl_f & scl_d & ~sda_d & sda_f;
    scl_rise_o = scl_f & ~scl_d;
    scl_fall_o = ~scl_f & scl_d;
  end
endmodule

// File: rtl/cfgi2c_cfg_reg.sv
module cfgi2c_cfg_reg #(
  parameter int unsigned      WIDTH   = 8,
  parameter logic [WIDTH-1:0] DEFAULT = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reload_i,
  input  logic             wr_en_i,
  input  logic [WIDTH-1:0] wr_data_i,
  output logic [WIDTH-1:0] value_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        value_o <= DEFAULT;
    else if (reload_i) value_o <= DEFAULT;
    else if (wr_en_i)  value_o <= wr_data_i;
  end
endmodule

// File: rtl/cfgi2c_target_fsm.sv
module cfgi2c_target_fsm
  import cfgi2c_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              sda_f,
  input  logic [ADDR_W-1:0] dev_addr_i,
  input  logic [BYTE_W-1:0] cur_value_i,
  output logic              wr_en_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              sda_pull_o
);
  localparam int unsigned BC_W = $clog2(BYTE_W + 1);

  tgt_state_t        state_q;
  logic [BC_W-1:0]   bits_q;
  logic [BYTE_W-1:0] rx_q;
  logic [BYTE_W-1:0] tx_q;
  logic              read_q;
  logic              byte_done;

  assign byte_done = (bits_q == BC_W'(BYTE_W));
  assign wr_data_o = rx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      bits_q     <= '0;
      rx_q       <= '0;
      tx_q       <= '0;
      read_q     <= 1'b0;
      sda_pull_o <= 1'b0;
      wr_en_o    <= 1'b0;
    end else begin
      wr_en_o <= 1'b0;
      if (start_i) begin
        state_q    <= ST_ADDR;
        bits_q     <= '0;
        sda_pull_o <= 1'b0;
      end else if (stop_i) begin
        state_q    <= ST_IDLE;
        sda_pull_o <= 1'b0;
      end else begin
        unique case (state_q)
          ST_ADDR, ST_WR_BYTE: begin
            if (scl_rise_i) begin
              rx_q   <= {rx_q[BYTE_W-2:0], sda_f};
              bits_q <= bits_q + 1'b1;
            end else if (scl_fall_i && byte_done) begin
              if (state_q == ST_WR_BYTE) begin
                sda_pull_o <= 1'b1;
                state_q    <= ST_WR_ACK;
              end else if (rx_q[BYTE_W-1:1] == dev_addr_i) begin
                sda_pull_o <= 1'b1;
                read_q     <= rx_q[0];
                state_q    <= ST_ADDR_ACK;
              end else begin
                state_q <= ST_PARK;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall_i) begin
              bits_q <= '0;
              if (read_q) begin
                tx_q       <= cur_value_i;
                sda_pull_o <= ~cur_value_i[BYTE_W-1];
                state_q    <= ST_RD_BYTE;
              end else begin
                sda_pull_o <= 1'b0;
                state_q    <= ST_WR_BYTE;
              end
            end
          end
          ST_WR_ACK: begin
            if (scl_fall_i) begin
              sda_pull_o <= 1'b0;
              wr_en_o    <= 1'b1;
              state_q    <= ST_PARK;
            end
          end
          ST_RD_BYTE: begin
            if (scl_rise_i) begin
              bits_q <= bits_q + 1'b1;
            end else if (scl_fall_i) begin
              if (byte_done) begin
                sda_pull_o <= 1'b0;
                state_q    <= ST_RD_ACK;
              end else begin
                tx_q       <= {tx_q[BYTE_W-2:0], 1'b1};
                sda_pull_o <= ~tx_q[BYTE_W-2];
              end
            end
          end
          ST_RD_ACK: begin
            if (scl_fall_i) state_q <= ST_PARK;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/cfg_i2c_target.sv
module cfg_i2c_target
  import cfgi2c_pkg::*;
#(
  parameter int unsigned      SYNC_STAGES = 2,
  parameter int unsigned      FILT_LEN    = 4,
  parameter logic [BYTE_W-1:0] DEFAULT_VAL = 8'h7A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_pull_o,
  input  logic [ADDR_W-1:0] dev_addr_i,
  input  logic              reload_i,
  output logic [CODE_W-1:0] bias_code_o,
  output logic [CODE_W-1:0] imp_code_o
);
  localparam int unsigned NLINES = 2;

  logic [NLINES-1:0] raw_lines, clean_lines;
  logic start_det, stop_det, scl_rise, scl_fall;
  logic wr_en;
  logic [BYTE_W-1:0] wr_data, cfg_value;

  assign raw_lines = {sda_i, scl_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    cfgi2c_line_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) i_filt (
      .clk(clk), .rst_n(rst_n), .raw_i(raw_lines[g]), .clean_o(clean_lines[g])
    );
  end

  cfgi2c_bus_events i_events (
    .clk(clk), .rst_n(rst_n),
    .scl_f(clean_lines[0]), .sda_f(clean_lines[1]),
    .start_o(start_det), .stop_o(stop_det),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall)
  );

  cfgi2c_target_fsm i_fsm (
    .clk(clk), .rst_n(rst_n),
    .start_i(start_det), .stop_i(stop_det),
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .sda_f(clean_lines[1]), .dev_addr_i(dev_addr_i),
    .cur_value_i(cfg_value), .wr_en_o(wr_en), .wr_data_o(wr_data),
    .sda_pull_o(sda_pull_o)
  );

  cfgi2c_cfg_reg #(.WIDTH(BYTE_W), .DEFAULT(DEFAULT_VAL)) i_reg (
    .clk(clk), .rst_n(rst_n), .reload_i(reload_i),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .value_o(cfg_value)
  );

  assign bias_code_o = cfg_value[BYTE_W-1:CODE_W];
  assign imp_code_o  = cfg_value[CODE_W-1:0];
endmodule

// File: rtl/cfg_i2c_target_chk.sv
module cfg_i2c_target_chk #(
  parameter logic [7:0] DEFAULT_VAL = 8'h7A
) (
  input logic       clk,
  input logic       rst_n,
  input logic       reload_i,
  input logic [3:0] bias_code_o,
  input logic [3:0] imp_code_o,
  input logic       sda_pull_o,
  input logic       start_det,
  input logic       stop_det,
  input logic       scl_fall,
  input logic       wr_en
);
  AST_RELOAD_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(reload_i) |-> ({bias_code_o, imp_code_o} == DEFAULT_VAL)); // R8
  AST_CFG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(wr_en) && !$past(reload_i)) |-> $stable({bias_code_o, imp_code_o})); // R3
  AST_WRITE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(scl_fall)); // R3
  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_pull_o); // R6
  AST_START_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !sda_pull_o); // R7
  AST_DRIVE_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull_o) |-> $past(scl_fall || start_det || stop_det)); // R4
endmodule

bind cfg_i2c_target cfg_i2c_target_chk #(.DEFAULT_VAL(DEFAULT_VAL)) i_chk (
  .clk(clk), .rst_n(rst_n), .reload_i(reload_i),
  .bias_code_o(bias_code_o), .imp_code_o(imp_code_o), .sda_pull_o(sda_pull_o),
  .start_det(start_det), .stop_det(stop_det), .scl_fall(scl_fall), .wr_en(wr_en)
);

// File: tb/test_cfg_i2c_target.sv
module test_cfg_i2c_target;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 16;
  localparam logic [6:0] MY_ADDR = 7'h2C;
  localparam logic [7:0] DEF = 8'h7A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic reload = 1'b0;
  logic sda_pull;
  logic [3:0] bias, imp;
  logic sda_line;
  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [7:0] model = DEF;

  assign sda_line = sda_m & ~sda_pull;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_i2c_target i_cfg_i2c_target (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_pull_o(sda_pull), .dev_addr_i(MY_ADDR), .reload_i(reload),
    .bias_code_o(bias), .imp_code_o(imp)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] addr_byte(input logic [6:0] a, input logic rd);
    return {a, rd};
  endfunction

  task automatic bus_start();
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(2*Q);
  endtask

  task automatic put_bit(input logic b, input bit glitch, output logic s);
    sda_m = b; tick(Q); scl_m = 1'b1;
    if (glitch) begin
      tick(Q/2); scl_m = 1'b0; tick(2); scl_m = 1'b1; tick(Q/2 - 2);
    end else tick(Q);
    s = sda_line; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit glitch, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) put_bit(b[i], glitch && (i == 3), s);
    put_bit(1'b1, 1'b0, s);
    ack = ~s;
  endtask

  task automatic get_byte(input logic mst_ack_bit, output logic [7:0] v, output logic rel9);
    logic s;
    v = '0;
    for (int i = 0; i < 8; i++) begin
      put_bit(1'b1, 1'b0, s);
      v = {v[6:0], s};
    end
    put_bit(mst_ack_bit, 1'b0, s);
    rel9 = s;
  endtask

  task automatic do_write(input logic [6:0] a, input logic [7:0] d, input bit glitch,
                          output logic aack, output logic dack);
    bus_start();
    send_byte(addr_byte(a, 1'b0), 1'b0, aack);
    send_byte(d, glitch, dack);
    bus_stop();
  endtask

  task automatic do_read(input logic [6:0] a, output logic aack, output logic [7:0] v,
                         output logic rel9);
    bus_start();
    send_byte(addr_byte(a, 1'b1), 1'b0, aack);
    get_byte(1'b1, v, rel9);
    bus_stop();
  endtask

  initial begin
    logic aack, dack, rel9, s;
    logic [7:0] v, d;
    logic [6:0] a;
    int kind;
    void'($urandom(32'h5EED1234));
    tick(5);
    check("R1 bias after reset", bias, 4'b0111);
    check("R1 imp after reset", imp, 4'b1010);
    check("R1 sda released", sda_pull, 1'b0);
    rst_n = 1'b1;
    tick(10);

    do_read(MY_ADDR, aack, v, rel9);
    check("R2 read address ack", aack, 1'b1);
    check("R4 read default", v, DEF);
    check("R4 released on ninth clock", rel9, 1'b1);

    do_write(MY_ADDR, 8'h3C, 1'b0, aack, dack);
    check("R2 write address ack", aack, 1'b1);
    check("R3 data ack", dack, 1'b1);
    check("R3 bias field", bias, 4'h3);
    check("R3 imp field", imp, 4'hC);
    model = 8'h3C;

    do_write(MY_ADDR ^ 7'h01, 8'h11, 1'b0, aack, dack);
    check("R10 no ack mismatch", aack, 1'b0);
    check("R10 no data ack mismatch", dack, 1'b0);
    check("R10 register kept", {bias, imp}, model);
    do_read(MY_ADDR ^ 7'h40, aack, v, rel9);
    check("R10 mismatch read all ones", v, 8'hFF);

    bus_start();
    send_byte(addr_byte(MY_ADDR, 1'b0), 1'b0, aack);
    send_byte(8'hA5, 1'b0, dack);
    send_byte(8'h0F, 1'b0, s);
    bus_stop();
    check("R5 first byte ack", dack, 1'b1);
    check("R5 second byte not acked", s, 1'b0);
    check("R5 register holds first byte", {bias, imp}, 8'hA5);
    model = 8'hA5;

    bus_start();
    send_byte(addr_byte(MY_ADDR, 1'b0), 1'b0, aack);
    for (int i = 0; i < 5; i++) put_bit(1'b0, 1'b0, s);
    bus_stop();
    check("R6 partial byte discarded", {bias, imp}, model);
    check("R6 sda released after stop", sda_pull, 1'b0);

    bus_start();
    send_byte(addr_byte(MY_ADDR, 1'b0), 1'b0, aack);
    for (int i = 0; i < 4; i++) put_bit(1'b1, 1'b0, s);
    bus_start();
    send_byte(addr_byte(MY_ADDR, 1'b0), 1'b0, aack);
    send_byte(8'h5C, 1'b0, dack);
    bus_stop();
    check("R7 restart address ack", aack, 1'b1);
    check("R7 restart write lands", {bias, imp}, 8'h5C);
    model = 8'h5C;

    tick(3); reload = 1'b1; tick(1); reload = 1'b0; tick(1);
    check("R8 reload default", {bias, imp}, DEF);
    model = DEF;

    do_write(MY_ADDR, 8'hC3, 1'b1, aack, dack);
    check("R9 scl glitch ignored", {bias, imp}, 8'hC3);
    model = 8'hC3;
    tick(Q); sda_m = 1'b0; tick(2); sda_m = 1'b1; tick(Q);
    do_read(MY_ADDR, aack, v, rel9);
    check("R9 sda glitch ignored", v, model);

    for (int n = 0; n < 30; n++) begin
      kind = $urandom % 3;
      d = 8'($urandom);
      if (kind == 0) begin
        do_write(MY_ADDR, d, 1'b0, aack, dack);
        model = d;
        check("R3 random write", {bias, imp}, model);
      end else if (kind == 1) begin
        do_read(MY_ADDR, aack, v, rel9);
        check("R4 random read", v, model);
      end else begin
        a = 7'($urandom);
        if (a == MY_ADDR) a = a ^ 7'h10;
        do_write(a, d, 1'b0, aack, dack);
        check("R2 random mismatch no ack", aack, 1'b0);
        check("R10 random mismatch kept", {bias, imp}, model);
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule